// File: doc/BRIEF.md
# Serial EEPROM Read Slave

This block is the slave side of a small serial memory that answers only the sequential-read command. A master pulls chip select low and shifts in an eight-bit command. In the largest size the command also holds the ninth address bit. A byte address follows. From the next serial clock on, the block returns array bytes on its serial output, most significant bit first. It moves to the following location after every byte, so one command can stream any number of bytes. The address wraps from the top of the array back to zero.

The serial clock, chip select and data input are brought into a faster system clock through synchronizers. The output pin is modelled as a data bit plus a drive enable. The array is a plain register file with a load port, so a test environment can fill it before use. A busy input stands for a write cycle in progress. While busy is high, the command is refused. A parameter picks an array of 512, 256 or 128 bytes. Address bits above the chosen width are dropped.

Top module: `spi_eeprom_reader`

## Requirements
- R1: After reset and during the 16 command and address clocks, `so_oe` is low. The first data bit is driven on the falling serial clock edge that follows the 16th rising edge.
- R2: A command is accepted only when bits 7..4 are 0000 and bits 2..0 are 011. Any other command keeps `so_oe` low until chip select rises.
- R3: In the 512-byte size, address bit 8 is taken from bit 3 of the command byte, and bits 7..0 come from the address byte.
- R4: Address bits above the configured width are ignored. For 256 bytes that is command bit 3. For 128 bytes it is also address byte bit 7.
- R5: Each byte goes out most significant bit first, one bit per falling serial clock edge, and it does not change between those edges.
- R6: After each byte, the address steps by one and the next byte follows with no further command.
- R7: After the highest location, the read continues at address 0.
- R8: When chip select goes high, at any bit and even in the middle of a byte, `so_oe` drops within a few system clocks.
- R9: If `busy` is high when the eighth command bit is sampled, the command is refused and `so_oe` stays low.
- R10: A load-port write of a byte at an address is what a later read of that address returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock; idles low, data sampled on rising edges |
| csn | input | 1 | Chip select, active low |
| si | input | 1 | Serial data input |
| busy | input | 1 | Write cycle in progress; a read command is refused while it is high |
| ld_we | input | 1 | Load-port write strobe for the array |
| ld_addr | input | AW | Load-port address |
| ld_data | input | 8 | Load-port data byte |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Drive enable for the serial output; low means high impedance |

## Verification
The hardest state to reach from the ports is a stream that runs past the top address. The bench gets there in two ways: it starts reads just below the top, and it runs one long read of several hundred bytes, so all three array sizes wrap while the stream continues. Three instances of the block, one per size, share the same serial lines. The same command and address byte therefore show that command bit 3 and address byte bit 7 are used or dropped as each size requires. Chip select is also raised three bits into a byte, and busy is held over a valid command, to show a transfer cut short and a refused command.

// File: rtl/spir_pkg.sv
package spir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_REJECT
  } rd_state_e;

  localparam logic [7:0] OP_MASK = 8'hF7;
  localparam logic [7:0] OP_READ = 8'h03;
endpackage

// File: rtl/spir_sync.sv
module spir_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= INIT;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spir_mem.sv
module spir_mem #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_eeprom_reader.sv
module spi_eeprom_reader
  import spir_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          csn,
  input  logic          si,
  input  logic          busy,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  output logic          so,
  output logic          so_oe
);
  logic [2:0] pins_q;
  logic       sck_q, csn_q, si_q, sck_d;
  logic       rise, fall;

  spir_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({si, csn, sck}),
    .q   (pins_q)
  );

  assign sck_q = pins_q[0];
  assign csn_q = pins_q[1];
  assign si_q  = pins_q[2];
  assign rise  = sck_q & ~sck_d;
  assign fall  = ~sck_q & sck_d;

  rd_state_e     state;
  logic [3:0]    hdr_cnt;
  logic [6:0]    in_sr;
  logic [7:0]    in_next;
  logic          a8;
  logic [8:0]    full_addr;
  logic [AW-1:0] addr;
  logic [2:0]    bit_idx;
  logic [6:0]    out_sr;
  logic [7:0]    rd_byte;

  assign in_next   = {in_sr, si_q};
  assign full_addr = {a8, in_next};

  spir_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (addr),
    .rdata (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      state   <= ST_IDLE;
      hdr_cnt <= '0;
      in_sr   <= '0;
      a8      <= 1'b0;
      addr    <= '0;
      bit_idx <= '0;
      out_sr  <= '0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      sck_d <= sck_q;
      if (csn_q) begin
        state   <= ST_IDLE;
        so_oe   <= 1'b0;
        hdr_cnt <= '0;
        bit_idx <= '0;
      end else begin
        case (state)
          ST_IDLE: state <= ST_CMD;
          ST_CMD: if (rise) begin
            in_sr   <= in_next[6:0];
            hdr_cnt <= hdr_cnt + 4'd1;
            if (hdr_cnt == 4'd7) begin
              if (((in_next & OP_MASK) == OP_READ) && !busy) begin
                a8    <= in_next[3];
                state <= ST_ADDR;
              end else begin
                state <= ST_REJECT;
              end
            end
          end
          ST_ADDR: if (rise) begin
            in_sr   <= in_next[6:0];
            hdr_cnt <= hdr_cnt + 4'd1;
            if (hdr_cnt == 4'd15) begin
              addr    <= full_addr[AW-1:0];
              bit_idx <= '0;
              state   <= ST_DATA;
            end
          end
          ST_DATA: if (fall) begin
            so_oe   <= 1'b1;
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd0) begin
              so     <= rd_byte[7];
              out_sr <= rd_byte[6:0];
              addr   <= addr + {{(AW-1){1'b0}}, 1'b1};
            end else begin
              so     <= out_sr[6];
              out_sr <= {out_sr[5:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: a high chip select silences the output on the next clock
  assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
    csn_q |=> !so_oe);

  // R1: the output is driven only in the data phase
  assert_drive_only_data_R1: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (state == ST_DATA));

  // R2: a refused command never drives the pin
  assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REJECT) |-> !so_oe);

  // R5: the output bit changes only on a falling serial clock
  assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(so));

  // R9: busy at the last command bit refuses the command
  assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (rst)
    (!csn_q && state == ST_CMD && rise && hdr_cnt == 4'd7 && busy)
      |=> (state == ST_REJECT));
endmodule

// File: tb/spi_eeprom_reader_tb.sv
module spi_eeprom_reader_tb;
  localparam int HALF = 12;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0, busy = 1'b0;
  logic [2:0] we = '0;
  logic [8:0] la = '0;
  logic [7:0] ld = '0;
  logic [2:0] so, soe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_eeprom_reader #(.MEM_BYTES(512), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .si(si), .busy(busy),
    .ld_we(we[0]), .ld_addr(la[8:0]), .ld_data(ld), .so(so[0]), .so_oe(soe[0]));
  spi_eeprom_reader #(.MEM_BYTES(256), .SYNC_STAGES(SYNC)) u_dut256 (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .si(si), .busy(busy),
    .ld_we(we[1]), .ld_addr(la[7:0]), .ld_data(ld), .so(so[1]), .so_oe(soe[1]));
  spi_eeprom_reader #(.MEM_BYTES(128), .SYNC_STAGES(SYNC)) u_dut128 (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .si(si), .busy(busy),
    .ld_we(we[2]), .ld_addr(la[6:0]), .ld_data(ld), .so(so[2]), .so_oe(soe[2]));

  function automatic logic [7:0] pat(int x);
    return 8'((x * 29 + (x >> 3) + 5) & 255);
  endfunction

  function automatic int size_of(int d);
    return (d == 0) ? 512 : ((d == 1) ? 256 : 128);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bitcyc(input logic b, output logic [2:0] s, output logic [2:0] e);
    si = b;
    half_wait();
    s = so;
    e = soe;
    sck = 1'b1;
    half_wait();
    sck = 1'b0;
  endtask

  task automatic txn(logic [7:0] op, logic [7:0] ab, int nbytes, int cut, string req);
    logic [2:0] s, e;
    logic [7:0] got [3];
    bit hdr_oe, bad_oe [3];
    bit acc;
    int base;
    acc = ((op & 8'hF7) == 8'h03) && !busy;
    base = {23'd0, op[3], ab};
    hdr_oe = 0;
    csn = 1'b0;
    half_wait();
    for (int i = 0; i < 16; i++) begin
      bitcyc((i < 8) ? op[7 - i] : ab[15 - i], s, e);
      if (e != 3'b000) hdr_oe = 1;
    end
    chk(!hdr_oe, "R1", hdr_oe, 0);
    for (int k = 0; k < nbytes; k++) begin
      for (int d = 0; d < 3; d++) bad_oe[d] = 0;
      for (int j = 0; j < 8; j++) begin
        bitcyc(1'b0, s, e);
        for (int d = 0; d < 3; d++) begin
          got[d][7 - j] = s[d];
          if (e[d] != acc) bad_oe[d] = 1;
        end
      end
      for (int d = 0; d < 3; d++) begin
        chk(!bad_oe[d], acc ? req : "R2", bad_oe[d], 0);
        if (acc)
          chk(got[d] == pat((base + k) & (size_of(d) - 1)), req, got[d],
              pat((base + k) & (size_of(d) - 1)));
      end
    end
    for (int j = 0; j < cut; j++) bitcyc(1'b0, s, e);
    csn = 1'b1;
    repeat (SYNC + 4) @(negedge clk);
    chk(soe == 3'b000, "R8", soe, 0);
    half_wait();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (8) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(soe == 3'b000, "R1", soe, 0);
    for (int x = 0; x < 512; x++) begin
      la = 9'(x);
      ld = pat(x);
      we = {x < 128, x < 256, 1'b1};
      @(negedge clk);
    end
    we = '0;
    @(negedge clk);

    txn(8'h03, 8'h00, 3, 0, "R5");
    txn(8'h0B, 8'h10, 2, 0, "R3");
    txn(8'h03, 8'h85, 2, 0, "R4");
    txn(8'h0B, 8'h85, 2, 0, "R4");
    txn(8'h0B, 8'hFE, 4, 0, "R7");
    txn(8'h03, 8'hFF, 3, 0, "R7");
    for (int hi = 0; hi < 2; hi++)
      for (int a = 0; a < 256; a += 17)
        txn(hi != 0 ? 8'h0B : 8'h03, 8'(a), 2, 0, "R6");
    txn(8'h03, 8'h40, 1, 3, "R8");
    txn(8'h13, 8'h00, 1, 0, "R2");
    txn(8'h83, 8'h00, 1, 0, "R2");
    txn(8'h02, 8'h00, 1, 0, "R2");
    txn(8'h07, 8'h00, 1, 0, "R2");
    txn(8'h43, 8'h00, 1, 0, "R2");
    busy = 1'b1;
    txn(8'h03, 8'h20, 1, 0, "R9");
    busy = 1'b0;
    txn(8'h03, 8'h20, 1, 0, "R9");
    txn(8'h0B, 8'hC0, 300, 0, "R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule